// File: doc/BRIEF.md
# Shift, Rotate and Byte-Swap Unit

This block is the execution stage for single-register shift instructions in a 16-bit processor datapath. Each accepted request carries a 3-bit operation code, a count bit that picks a one- or two-position move, the operand, and the current carry and overflow flags. One clock later the block presents the result, new values for the sign, zero, carry and overflow flags, and one write-enable per flag. The register file and the status register use those enables to decide what to commit.

Eight operations share the unit:
- byte swap;
- logical shifts left and right;
- arithmetic shift right;
- rotates left and right through carry;
- a left shift into carry;
- an arithmetic right shift into carry.

For a two-position move, the operations that involve carry keep the second bit that leaves the word in the overflow flag. The two rotates feed the old overflow back in as the second incoming bit. A two-position swap does not swap twice: it copies the low byte into both halves.

A flag whose enable is low is still driven on its output, holding the incoming value, so the outputs are defined in every cycle that `res_valid` is high.

Top module: `shrot_unit`

## Requirements
- R1: With operation code 000 and count 0, the result is the operand with its two bytes exchanged. S is result bit 7, and Z is 1 exactly when result bits 7..0 are all zero.
- R2: With operation code 000 and count 1, both bytes of the result equal the operand's low byte. S and Z come from that byte: S is its bit 7, and Z is 1 when it is zero.
- R3: Operation codes 001 (shift left) and 100 (logical shift right) move the operand by one position when count is 0 and by two when count is 1. Zeros fill the vacated positions.
- R4: Operation codes 101 and 111 shift right arithmetically by one or two positions. Operand bit 15 is copied into every vacated position.
- R5: For a one-position rotate, operation code 010 (left) puts the incoming C into bit 0, and operation code 110 (right) puts it into bit 15. The bit that leaves the word becomes the new C.
- R6: For a two-position rotate, the incoming C and then the incoming O are rotated in. The result is {op[13:0],C,O} for left and {O,C,op[15:2]} for right. The first bit that leaves the word becomes C, and the second becomes O.
- R7: Operation codes 011 (left) and 111 (right) put the first bit that leaves the word into C. With count 1 they also put the second bit into O.
- R8: For every accepted request, the S and Z enables are 1. The C enable is 1 only for operation codes 010, 011, 110 and 111. The O enable is 1 only for those four codes with count 1.
- R9: For every operation other than a one-position swap, S is result bit 15 and Z is 1 exactly when the whole result is zero.
- R10: Results appear one clock after `req_valid`, with `res_valid` high for exactly that cycle. A flag whose enable is 0 outputs the incoming flag value unchanged. After reset, `res_valid` and all enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Operation code |
| req_twice | input | 1 | 0 = one position, 1 = two positions |
| req_data | input | 16 | Operand |
| req_c | input | 1 | Incoming carry flag |
| req_o | input | 1 | Incoming overflow flag |
| res_valid | output | 1 | Result strobe |
| res_data | output | 16 | Result |
| res_s | output | 1 | New sign flag |
| res_z | output | 1 | New zero flag |
| res_c | output | 1 | New carry flag |
| res_o | output | 1 | New overflow flag |
| we_s | output | 1 | Sign flag write-enable |
| we_z | output | 1 | Zero flag write-enable |
| we_c | output | 1 | Carry flag write-enable |
| we_o | output | 1 | Overflow flag write-enable |

## Verification
The block holds state only in its output stage, so a wrong decode, fill bit or flag choice appears on the very next `res_valid` cycle. It shows as a wrong result or flag value, or as an enable that would let the status register take an unrelated flag. A wrong enable is the subtle case: it leaves the visible data correct and only corrupts the carry or overflow committed downstream. For that reason every comparison covers all four enables and all four flag values alongside the result.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
  typedef enum logic [2:0] {
    OP_SWAP = 3'b000,
    OP_SHL  = 3'b001,
    OP_ROL  = 3'b010,
    OP_SHLC = 3'b011,
    OP_SHR  = 3'b100,
    OP_ASR  = 3'b101,
    OP_ROR  = 3'b110,
    OP_ASRC = 3'b111
  } shrot_op_e;

  // codes with bit 1 set move bits through the carry flag
  function automatic logic uses_carry(input logic [2:0] op);
    return op[1];
  endfunction
endpackage

// File: rtl/shrot_datapath.sv
module shrot_datapath
  import shrot_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [2:0]   op,
  input  logic         twice,
  input  logic [W-1:0] din,
  input  logic         cin,
  input  logic         oin,
  output logic [W-1:0] dout,
  output logic         first_out,
  output logic         second_out
);
  localparam int HALF = W / 2;

  logic [1:0]   amt;
  logic [W-1:0] asr_val;
  logic [HALF-1:0] lo;
  logic [HALF-1:0] hi;

  assign amt     = twice ? 2'd2 : 2'd1;
  assign lo      = din[HALF-1:0];
  assign hi      = din[W-1:HALF];
  assign asr_val = W'($signed(din) >>> amt);

  always_comb begin
    dout       = din;
    first_out  = 1'b0;
    second_out = 1'b0;
    unique case (shrot_op_e'(op))
      OP_SWAP: dout = twice ? {lo, lo} : {lo, hi};
      OP_SHL:  dout = din << amt;
      OP_SHR:  dout = din >> amt;
      OP_ASR:  dout = asr_val;
      OP_ROL: begin
        dout       = twice ? {din[W-3:0], cin, oin} : {din[W-2:0], cin};
        first_out  = din[W-1];
        second_out = din[W-2];
      end
      OP_SHLC: begin
        dout       = din << amt;
        first_out  = din[W-1];
        second_out = din[W-2];
      end
      OP_ROR: begin
        dout       = twice ? {oin, cin, din[W-1:2]} : {cin, din[W-1:1]};
        first_out  = din[0];
        second_out = din[1];
      end
      OP_ASRC: begin
        dout       = asr_val;
        first_out  = din[0];
        second_out = din[1];
      end
      default: dout = din;
    endcase
  end
endmodule

// File: rtl/shrot_flags.sv
module shrot_flags
  import shrot_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [2:0]   op,
  input  logic         twice,
  input  logic [W-1:0] result,
  input  logic         first_out,
  input  logic         second_out,
  input  logic         cin,
  input  logic         oin,
  output logic         s_new,
  output logic         z_new,
  output logic         c_new,
  output logic         o_new,
  output logic         c_en,
  output logic         o_en
);
  localparam int HALF = W / 2;

  logic byte_mode;
  assign byte_mode = (shrot_op_e'(op) == OP_SWAP) && !twice;

  always_comb begin
    if (byte_mode) begin
      s_new = result[HALF-1];
      z_new = (result[HALF-1:0] == '0);
    end else begin
      s_new = result[W-1];
      z_new = (result == '0);
    end
  end

  assign c_en  = uses_carry(op);
  assign o_en  = uses_carry(op) && twice;
  assign c_new = c_en ? first_out  : cin;
  assign o_new = o_en ? second_out : oin;
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
  import shrot_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         req_valid,
  input  logic [2:0]   req_op,
  input  logic         req_twice,
  input  logic [W-1:0] req_data,
  input  logic         req_c,
  input  logic         req_o,
  output logic         res_valid,
  output logic [W-1:0] res_data,
  output logic         res_s,
  output logic         res_z,
  output logic         res_c,
  output logic         res_o,
  output logic         we_s,
  output logic         we_z,
  output logic         we_c,
  output logic         we_o
);
  logic [W-1:0] dp_out;
  logic         out1, out2;
  logic         s_n, z_n, c_n, o_n, c_en, o_en;

  shrot_datapath #(.W(W)) u_dp (
    .op(req_op), .twice(req_twice), .din(req_data), .cin(req_c), .oin(req_o),
    .dout(dp_out), .first_out(out1), .second_out(out2)
  );

  shrot_flags #(.W(W)) u_fl (
    .op(req_op), .twice(req_twice), .result(dp_out), .first_out(out1),
    .second_out(out2), .cin(req_c), .oin(req_o), .s_new(s_n), .z_new(z_n),
    .c_new(c_n), .o_new(o_n), .c_en(c_en), .o_en(o_en)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_data  <= '0;
      res_s     <= 1'b0;
      res_z     <= 1'b0;
      res_c     <= 1'b0;
      res_o     <= 1'b0;
      we_s      <= 1'b0;
      we_z      <= 1'b0;
      we_c      <= 1'b0;
      we_o      <= 1'b0;
    end else begin
      res_valid <= req_valid;
      we_s      <= req_valid;
      we_z      <= req_valid;
      we_c      <= req_valid && c_en;
      we_o      <= req_valid && o_en;
      if (req_valid) begin
        res_data <= dp_out;
        res_s    <= s_n;
        res_z    <= z_n;
        res_c    <= c_n;
        res_o    <= o_n;
      end
    end
  end

  // R10
  valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid == $past(req_valid));
  // R8
  o_needs_c_chk: assert property (@(posedge clk) disable iff (rst)
    we_o |-> (we_c && $past(req_twice)));
  // R8
  enables_only_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> !(we_s || we_z || we_c || we_o));
  // R9
  zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !($past(req_op) == 3'b000 && !$past(req_twice)))
      |-> (res_z == (res_data == '0)));
  // R4
  sign_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && $past(req_op) == 3'b101)
      |-> (res_data[W-1] == $past(req_data[W-1])));
  // R10
  carry_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !we_c) |-> (res_c == $past(req_c)));
endmodule

// File: tb/shrot_unit_bench.sv
module shrot_unit_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic req_twice = 1'b0;
  logic [15:0] req_data = '0;
  logic req_c = 1'b0, req_o = 1'b0;
  logic res_valid;
  logic [15:0] res_data;
  logic res_s, res_z, res_c, res_o, we_s, we_z, we_c, we_o;

  int checks = 0;
  int errors = 0;
  logic [23:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  shrot_unit u_shrot_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_twice(req_twice), .req_data(req_data), .req_c(req_c), .req_o(req_o),
    .res_valid(res_valid), .res_data(res_data), .res_s(res_s), .res_z(res_z),
    .res_c(res_c), .res_o(res_o), .we_s(we_s), .we_z(we_z), .we_c(we_c),
    .we_o(we_o)
  );

  // reference model: one position per step, bits leaving the word collected in order
  function automatic logic [23:0] model(input logic [2:0] op, input logic tw,
                                        input logic [15:0] x, input logic c,
                                        input logic o);
    logic [15:0] v = x;
    logic [1:0] outs = 2'b00;
    logic s, z, nc, no, ce, oe;
    int steps = tw ? 2 : 1;
    logic fill;
    if (op == 3'd0) begin
      v = tw ? {x[7:0], x[7:0]} : {x[7:0], x[15:8]};
    end else begin
      for (int k = 0; k < steps; k++) begin
        if (op == 3'd2 || op == 3'd6) fill = (k == 0) ? c : o;
        else if (op == 3'd5 || op == 3'd7) fill = x[15];
        else fill = 1'b0;
        if (op == 3'd1 || op == 3'd2 || op == 3'd3) begin
          outs[k] = v[15];
          v = {v[14:0], fill};
        end else begin
          outs[k] = v[0];
          v = {fill, v[15:1]};
        end
      end
    end
    if (op == 3'd0 && !tw) begin
      s = v[7]; z = (v[7:0] == 8'h00);
    end else begin
      s = v[15]; z = (v == 16'h0000);
    end
    ce = (op == 3'd2 || op == 3'd3 || op == 3'd6 || op == 3'd7);
    oe = ce && tw;
    nc = ce ? outs[0] : c;
    no = oe ? outs[1] : o;
    return {v, s, z, nc, no, 1'b1, 1'b1, ce, oe};
  endfunction

  task automatic drive(input logic [2:0] op, input logic tw, input logic [15:0] x,
                       input logic c, input logic o, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_twice = tw; req_data = x;
    req_c = c; req_o = o;
    exp_q.push_back(model(op, tw, x, c, o));
    tag_q.push_back(tag);
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      logic [23:0] got;
      logic [23:0] exp;
      string tag;
      got = {res_data, res_s, res_z, res_c, res_o, we_s, we_z, we_c, we_o};
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R10 unexpected result got=%h expected=none", got);
      end else begin
        exp = exp_q.pop_front();
        tag = tag_q.pop_front();
        if (got !== exp) begin
          errors++;
          $display("FAIL %s got data=%h flags(szco)=%b we(szco)=%b expected data=%h flags=%b we=%b",
                   tag, got[23:8], got[7:4], got[3:0], exp[23:8], exp[7:4], exp[3:0]);
        end
      end
    end
  end

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        checks++;
        if (res_valid !== 1'b0 || {we_s, we_z, we_c, we_o} !== 4'b0) begin
          errors++;
          $display("FAIL R10 reset got valid=%b we=%b expected 0 0000", res_valid,
                   {we_s, we_z, we_c, we_o});
        end
        drive(3'd0, 1'b0, 16'h12F0, 1'b0, 1'b0, "R1");  // R1 swap, low byte 0x12
        drive(3'd0, 1'b0, 16'h8000, 1'b1, 1'b1, "R1");  // R1 low byte 0x80: S=1
        drive(3'd0, 1'b0, 16'h0055, 1'b0, 1'b0, "R1");  // R1 low byte zero: Z=1
        drive(3'd0, 1'b1, 16'h34A7, 1'b0, 1'b1, "R2");  // R2 replicate
        drive(3'd0, 1'b1, 16'hFF00, 1'b1, 1'b0, "R2");  // R2 zero low byte
        drive(3'd1, 1'b0, 16'hC001, 1'b1, 1'b1, "R3");  // R3
        drive(3'd1, 1'b1, 16'hC001, 1'b1, 1'b1, "R3");  // R3
        drive(3'd4, 1'b1, 16'h8003, 1'b0, 1'b0, "R3");  // R3
        drive(3'd5, 1'b0, 16'h8002, 1'b0, 1'b1, "R4");  // R4
        drive(3'd5, 1'b1, 16'h4003, 1'b1, 1'b0, "R4");  // R4
        drive(3'd2, 1'b0, 16'h8000, 1'b1, 1'b0, "R5");  // R5
        drive(3'd6, 1'b0, 16'h0001, 1'b0, 1'b1, "R5");  // R5
        drive(3'd2, 1'b1, 16'h4000, 1'b1, 1'b0, "R6");  // R6
        drive(3'd6, 1'b1, 16'h0002, 1'b0, 1'b1, "R6");  // R6
        drive(3'd3, 1'b1, 16'h8000, 1'b0, 1'b1, "R7");  // R7
        drive(3'd7, 1'b1, 16'h8001, 1'b0, 1'b0, "R7");  // R7
        drive(3'd7, 1'b0, 16'h0000, 1'b1, 1'b1, "R9");  // R9 zero result
        for (int i = 0; i < 400; i++)  // R8 enables on every op/count combination
          drive(3'(i % 8), 1'((i / 8) % 2), 16'($urandom), 1'($urandom), 1'($urandom), "R8");
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        // R10 no result without a request
        checks++;
        if (res_valid !== 1'b0 || exp_q.size() != 0) begin
          errors++;
          $display("FAIL R10 idle got valid=%b pending=%0d expected 0 0", res_valid, exp_q.size());
        end
      end
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL R10 watchdog got timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule